// File: doc/BRIEF.md
# Coherent Line Controller with Write-Intent Prefetch

This block keeps the coherence state of every line of a small direct-mapped cache belonging to one core. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The core sends four kinds of request: load, store, read prefetch and write prefetch. The controller looks the line up and finishes hits locally. On a miss, or when a store needs ownership, it raises one request on a snooping bus. The request either reads the line for sharing or takes ownership of it. The controller also watches snoops from other cores and downgrades, invalidates or writes back its own copy.

Prefetches are hints only. The controller always takes them at once and returns nothing. It never holds the core back for one, and it drops a prefetch without a fault when the address did not translate. A write prefetch takes ownership ahead of a later store, so that store finishes with no bus traffic. A configuration input can turn write prefetching off; each write prefetch then becomes a read prefetch. A locality hint travels with read prefetches onto the bus and is dropped for ownership requests.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, and the first load to any address raises one read-for-sharing request (`bus_req_own`=0) whose `bus_req_addr` equals the load address.
- R2: A load miss fills the line Exclusive when `bus_shared` is low with `bus_done`, and Shared when it is high. The load's `req_ready` rises in the cycle after `bus_done`, with no second bus request.
- R3: A store to an Invalid or Shared line raises an ownership request (`bus_req_own`=1) before it completes. A store to an Exclusive or Modified line completes in its first cycle with no bus request, and the line becomes Modified.
- R4: A read-for-sharing snoop (`snp_own`=0) that hits a valid line raises `snp_hit` one cycle later. It also raises `snp_wb` if the line was Modified. Modified and Exclusive lines become Shared.
- R5: An ownership snoop (`snp_own`=1) that hits a valid line raises `snp_hit`, raises `snp_wb` if the line was Modified, and leaves the line Invalid.
- R6: A read prefetch (`req_kind`=2) always sees `req_ready` high in its first cycle. If it misses, it raises a read-for-sharing request carrying its 2-bit hint on `bus_req_hint`. If it hits, it raises nothing.
- R7: With `wp_enable` high, a write prefetch (`req_kind`=3) to an Invalid or Shared line raises an ownership request with `bus_req_hint` forced to 0 whatever the input hint. It leaves the line Exclusive, so a later store completes with no bus request.
- R8: With `wp_enable` low, a write prefetch behaves exactly as a read prefetch: a read-for-sharing request that carries the input hint.
- R9: A prefetch with `req_addr_ok` low is accepted, raises no bus request and leaves the line state unchanged.
- R10: At most one bus request is outstanding. A prefetch that arrives while one is outstanding is accepted and dropped. A demand waits with `req_ready` low, and a load to the line already being fetched completes from that fill without a second request.
- R11: Once raised, `bus_req_valid`, `bus_req_addr` and `bus_req_own` stay unchanged until the cycle of `bus_done`.
- R12: A miss that replaces a Modified line of another tag raises `bus_req_wb` with its request. A miss that replaces a clean line does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_enable | input | 1 | Enables write-intent prefetch; low turns it into read prefetch |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted / demand completed |
| req_kind | input | 2 | 0 load, 1 store, 2 read prefetch, 3 write prefetch |
| req_addr | input | AW | Line address of the request |
| req_hint | input | 2 | Locality hint (0 non-temporal … 3 highest) |
| req_addr_ok | input | 1 | Address translated; a prefetch with this low is dropped |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_own | output | 1 | 1 ownership request, 0 read-for-sharing |
| bus_req_addr | output | AW | Line address on the bus |
| bus_req_hint | output | 2 | Locality hint carried with a read prefetch |
| bus_req_wb | output | 1 | Modified victim is written back with this request |
| bus_done | input | 1 | Bus request completed (one cycle) |
| bus_shared | input | 1 | Another cache holds the line, valid with bus_done |
| snp_valid | input | 1 | Snoop from another core |
| snp_own | input | 1 | Snoop is an ownership request |
| snp_addr | input | AW | Snooped line address |
| snp_hit | output | 1 | Local copy was valid (one cycle after snoop) |
| snp_wb | output | 1 | Local copy was Modified and is written back |

## Verification
The bench builds the block with an 8-bit address and 3 index bits, so only eight lines exist. Two addresses that share low bits therefore collide in one slot, which brings the replacement of a Modified line and of a clean line within reach in a few requests. Snoops serve as the probe of line state. A read-for-sharing snoop tells Modified (writeback) from a clean valid copy, an ownership snoop tells valid from Invalid, and a following store tells Exclusive (no bus traffic) from Shared (ownership request).

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_E = 2'b10,
    LS_M = 2'b11
  } lstate_t;

  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_STORE = 2'd1,
    RQ_PFR   = 2'd2,
    RQ_PFW   = 2'd3
  } rkind_t;

  // State a valid local copy takes after a snoop of the given kind
  function automatic lstate_t snoop_next(input lstate_t cur, input logic own);
    if (own || cur == LS_I) return LS_I;
    return LS_S;
  endfunction

  function automatic logic holds_ownership(input lstate_t cur);
    return (cur == LS_E) || (cur == LS_M);
  endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output lstate_t          rd_state,
  input  logic [IDX_W-1:0] sp_idx,
  output logic [TAG_W-1:0] sp_tag,
  output lstate_t          sp_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  lstate_t          wr_state,
  input  logic             sw_en,
  input  logic [IDX_W-1:0] sw_idx,
  input  lstate_t          sw_state
);
  localparam int LINES = 1 << IDX_W;

  lstate_t          st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // core-side write (fill or store hit) wins over a snoop update
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i] <= LS_I;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        st_q[i] <= wr_state;
      end else if (sw_en && sw_idx == IDX_W'(i)) begin
        st_q[i] <= sw_state;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i)) tag_q[i] <= wr_tag;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];
  assign sp_tag   = tag_q[sp_idx];
  assign sp_state = st_q[sp_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snp_valid,
  input  logic             snp_own,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  lstate_t          line_state,
  output logic             upd_en,
  output lstate_t          upd_state,
  output logic             hit_q,
  output logic             wb_q
);
  logic hit;

  assign hit       = snp_valid && (line_state != LS_I) && (line_tag == snp_tag);
  assign upd_en    = hit;
  assign upd_state = snoop_next(line_state, snp_own);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      wb_q  <= 1'b0;
    end else begin
      hit_q <= hit;
      wb_q  <= hit && (line_state == LS_M);
    end
  end

endmodule

// File: rtl/coh_miss_fsm.sv
module coh_miss_fsm #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_own,
  input  logic [1:0]    start_hint,
  input  logic          start_wb,
  input  logic          bus_done,
  output logic          busy,
  output logic          fill,
  output logic [AW-1:0] req_addr,
  output logic          req_own,
  output logic [1:0]    req_hint,
  output logic          req_wb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      req_addr <= '0;
      req_own  <= 1'b0;
      req_hint <= 2'd0;
      req_wb   <= 1'b0;
    end else if (busy) begin
      if (bus_done) begin
        busy   <= 1'b0;
        req_wb <= 1'b0;
      end
    end else if (start) begin
      busy     <= 1'b1;
      req_addr <= start_addr;
      req_own  <= start_own;
      req_hint <= start_hint;
      req_wb   <= start_wb;
    end
  end

  assign fill = busy && bus_done;

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wp_enable,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_hint,
  input  logic          req_addr_ok,
  output logic          bus_req_valid,
  output logic          bus_req_own,
  output logic [AW-1:0] bus_req_addr,
  output logic [1:0]    bus_req_hint,
  output logic          bus_req_wb,
  input  logic          bus_done,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic          snp_own,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hit,
  output logic          snp_wb
);
  localparam int TAG_W = AW - IDX_W;

  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic [TAG_W-1:0] rd_tag;
  lstate_t          rd_state;
  logic [TAG_W-1:0] sp_tag;
  lstate_t          sp_state;
  logic             sw_en;
  lstate_t          sw_state;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  lstate_t          wr_state;
  logic             busy;
  logic             fill;
  logic             start;
  logic             start_own;
  logic [1:0]       start_hint;
  logic             hit;
  logic             owned;
  logic             free;
  logic             victim_wb;
  rkind_t           kind_eff;

  assign c_idx = req_addr[IDX_W-1:0];
  assign c_tag = req_addr[AW-1:IDX_W];

  // A disabled write prefetch is folded into a read prefetch here
  always_comb begin
    kind_eff = rkind_t'(req_kind);
    if (kind_eff == RQ_PFW && !wp_enable) kind_eff = RQ_PFR;
  end

  assign hit       = (rd_state != LS_I) && (rd_tag == c_tag);
  assign owned     = hit && holds_ownership(rd_state);
  assign free      = !busy && !snp_valid;
  assign victim_wb = (rd_state == LS_M) && (rd_tag != c_tag);

  // Core-side decision
  always_comb begin
    req_ready  = 1'b0;
    start      = 1'b0;
    start_own  = 1'b0;
    start_hint = 2'd0;
    if (req_valid) begin
      unique case (kind_eff)
        RQ_LOAD: begin
          if (free) begin
            if (hit) req_ready = 1'b1;
            else     start     = 1'b1;
          end
        end
        RQ_STORE: begin
          if (free) begin
            if (owned) begin
              req_ready = 1'b1;
            end else begin
              start     = 1'b1;
              start_own = 1'b1;
            end
          end
        end
        RQ_PFR: begin
          req_ready = 1'b1;
          if (free && req_addr_ok && !hit) begin
            start      = 1'b1;
            start_hint = req_hint;
          end
        end
        RQ_PFW: begin
          req_ready = 1'b1;
          if (free && req_addr_ok && !owned) begin
            start     = 1'b1;
            start_own = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Array write: fill on completion, or store hit moving the line to Modified
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = c_idx;
    wr_tag   = c_tag;
    wr_state = LS_M;
    if (fill) begin
      wr_en    = 1'b1;
      wr_idx   = bus_req_addr[IDX_W-1:0];
      wr_tag   = bus_req_addr[AW-1:IDX_W];
      wr_state = (bus_req_own || !bus_shared) ? LS_E : LS_S;
    end else if (req_valid && kind_eff == RQ_STORE && free && owned) begin
      wr_en = 1'b1;
    end
  end

  coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (c_idx),
    .rd_tag   (rd_tag),
    .rd_state (rd_state),
    .sp_idx   (snp_addr[IDX_W-1:0]),
    .sp_tag   (sp_tag),
    .sp_state (sp_state),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_state (wr_state),
    .sw_en    (sw_en),
    .sw_idx   (snp_addr[IDX_W-1:0]),
    .sw_state (sw_state)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk        (clk),
    .rst        (rst),
    .snp_valid  (snp_valid),
    .snp_own    (snp_own),
    .snp_tag    (snp_addr[AW-1:IDX_W]),
    .line_tag   (sp_tag),
    .line_state (sp_state),
    .upd_en     (sw_en),
    .upd_state  (sw_state),
    .hit_q      (snp_hit),
    .wb_q       (snp_wb)
  );

  coh_miss_fsm #(.AW(AW)) u_miss (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (req_addr),
    .start_own  (start_own),
    .start_hint (start_hint),
    .start_wb   (victim_wb),
    .bus_done   (bus_done),
    .busy       (busy),
    .fill       (fill),
    .req_addr   (bus_req_addr),
    .req_own    (bus_req_own),
    .req_hint   (bus_req_hint),
    .req_wb     (bus_req_wb)
  );

  assign bus_req_valid = busy;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic          bus_req_valid,
  input logic          bus_req_own,
  input logic [AW-1:0] bus_req_addr,
  input logic [1:0]    bus_req_hint,
  input logic          bus_done,
  input logic          snp_hit,
  input logic          snp_wb
);
  // R11: an open request holds its fields until completion
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_done) |=> (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_own)));

  // R6: prefetches never stall the core
  p_pf_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[1]) |-> req_ready);

  // R7: ownership requests carry no locality hint
  p_own_nohint_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_own) |-> (bus_req_hint == 2'd0));

  // R10: a demand cannot complete while a bus request is open
  p_demand_wait_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && req_valid && !req_kind[1]) |-> !req_ready);

  // R4: a writeback answer only comes with a hit answer
  p_wb_hit_r4: assert property (@(posedge clk) disable iff (rst)
    snp_wb |-> snp_hit);

  // R1: nothing is open right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> !bus_req_valid);

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_kind      (req_kind),
  .bus_req_valid (bus_req_valid),
  .bus_req_own   (bus_req_own),
  .bus_req_addr  (bus_req_addr),
  .bus_req_hint  (bus_req_hint),
  .bus_done      (bus_done),
  .snp_hit       (snp_hit),
  .snp_wb        (snp_wb)
);

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  localparam int AW = 8;
  localparam int IDX_W = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_enable = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_hint = 2'd0;
  logic          req_addr_ok = 1'b1;
  logic          bus_req_valid;
  logic          bus_req_own;
  logic [AW-1:0] bus_req_addr;
  logic [1:0]    bus_req_hint;
  logic          bus_req_wb;
  logic          bus_done = 1'b0;
  logic          bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic          snp_own = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_hit;
  logic          snp_wb;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  coh_line_ctrl #(.AW(AW), .IDX_W(IDX_W)) i_coh_line_ctrl (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issues one request, serves any bus request, returns what the bus saw
  task automatic run_req(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] h,
                         input logic ok, input logic sh, output int n, output logic own,
                         output logic [1:0] hint, output logic wb, output logic [AW-1:0] ra);
    int idle = 0;
    logic acc = 1'b0;
    n = 0; own = 1'b0; hint = 2'd0; wb = 1'b0; ra = '0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_hint = h; req_addr_ok = ok;
    for (int c = 0; c < 60 && idle < 2; c++) begin
      #1;
      if (bus_req_valid && !bus_done) begin
        n++; own = bus_req_own; hint = bus_req_hint; wb = bus_req_wb; ra = bus_req_addr;
        bus_done = 1'b1; bus_shared = sh;
      end else if (acc && !bus_req_valid) begin
        idle++;
      end
      if (req_valid && req_ready) acc = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_done = 1'b0;
      if (acc) req_valid = 1'b0;
    end
    if (!acc) chk(1'b0, "handshake", 0, 1);
    req_addr_ok = 1'b1;
  endtask

  task automatic snoop(input logic own_k, input logic [AW-1:0] a, output logic h, output logic w);
    @(negedge clk);
    snp_valid = 1'b1; snp_own = own_k; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    h = snp_hit; w = snp_wb;
  endtask

  task automatic t_reset();
    int n; logic o, w; logic [1:0] h; logic [AW-1:0] ra;
    chk(bus_req_valid == 1'b0, "R1 idle after reset", int'(bus_req_valid), 0);
    chk(snp_hit == 1'b0, "R1 no snoop hit after reset", int'(snp_hit), 0);
    run_req(2'd0, 8'h11, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b0, "R1 first load reads shared", n, 1);
    chk(ra == 8'h11, "R1 request address", int'(ra), 'h11);
  endtask

  task automatic t_load_exclusive();
    int n; logic o, w, sh, sw; logic [1:0] h; logic [AW-1:0] ra;
    run_req(2'd0, 8'h12, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1, "R2 load miss one request", n, 1);
    run_req(2'd1, 8'h12, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 0, "R3 store to Exclusive silent", n, 0);
    snoop(1'b0, 8'h12, sh, sw);
    chk(sh && sw, "R4 Modified answers read snoop with writeback", int'(sw), 1);
    snoop(1'b0, 8'h12, sh, sw);
    chk(sh && !sw, "R4 line downgraded to Shared", int'(sw), 0);
    run_req(2'd1, 8'h12, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b1, "R3 store to Shared asks ownership", int'(o), 1);
    snoop(1'b1, 8'h12, sh, sw);
    chk(sh && sw, "R5 ownership snoop writes back Modified", int'(sw), 1);
    snoop(1'b1, 8'h12, sh, sw);
    chk(!sh, "R5 line Invalid after ownership snoop", int'(sh), 0);
  endtask

  task automatic t_load_shared();
    int n; logic o, w, sh, sw; logic [1:0] h; logic [AW-1:0] ra;
    run_req(2'd0, 8'h13, 2'd0, 1'b1, 1'b1, n, o, h, w, ra);
    run_req(2'd1, 8'h13, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b1, "R2 shared fill needs ownership for store", n, 1);
    snoop(1'b0, 8'h13, sh, sw);
    chk(sw, "R3 store leaves line Modified", int'(sw), 1);
  endtask

  task automatic t_read_pf();
    int n; logic o, w; logic [1:0] h; logic [AW-1:0] ra;
    run_req(2'd2, 8'h14, 2'd2, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b0, "R6 read prefetch reads shared", int'(o), 0);
    chk(h == 2'd2, "R6 hint carried", int'(h), 2);
    run_req(2'd2, 8'h14, 2'd1, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 0, "R6 prefetch hit silent", n, 0);
    run_req(2'd0, 8'h14, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 0, "R6 load hits prefetched line", n, 0);
  endtask

  task automatic t_write_pf();
    int n; logic o, w, sh, sw; logic [1:0] h; logic [AW-1:0] ra;
    wp_enable = 1'b1;
    run_req(2'd3, 8'h15, 2'd3, 1'b1, 1'b1, n, o, h, w, ra);
    chk(n == 1 && o == 1'b1, "R7 write prefetch asks ownership", int'(o), 1);
    chk(h == 2'd0, "R7 hint ignored", int'(h), 0);
    run_req(2'd1, 8'h15, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 0, "R7 later store silent", n, 0);
    snoop(1'b0, 8'h15, sh, sw);
    chk(sw, "R7 store made line Modified", int'(sw), 1);
    run_req(2'd0, 8'h16, 2'd0, 1'b1, 1'b1, n, o, h, w, ra);
    run_req(2'd3, 8'h16, 2'd2, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b1, "R7 write prefetch upgrades Shared", int'(o), 1);
  endtask

  task automatic t_wp_off();
    int n; logic o, w; logic [1:0] h; logic [AW-1:0] ra;
    wp_enable = 1'b0;
    run_req(2'd3, 8'h17, 2'd1, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && o == 1'b0, "R8 disabled write prefetch reads shared", int'(o), 0);
    chk(h == 2'd1, "R8 hint kept", int'(h), 1);
    wp_enable = 1'b1;
  endtask

  task automatic t_bad_addr();
    int n; logic o, w, sh, sw; logic [1:0] h; logic [AW-1:0] ra;
    run_req(2'd2, 8'h20, 2'd3, 1'b0, 1'b0, n, o, h, w, ra);
    chk(n == 0, "R9 untranslated prefetch dropped", n, 0);
    snoop(1'b1, 8'h20, sh, sw);
    chk(!sh, "R9 line still Invalid", int'(sh), 0);
  endtask

  task automatic t_merge();
    int n; int reqs = 0; logic o, w, sh, sw; logic [1:0] h; logic [AW-1:0] ra;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h30; req_hint = 2'd3;
    #1;
    chk(req_ready, "R6 prefetch accepted at once", int'(req_ready), 1);
    @(negedge clk);
    req_kind = 2'd0;
    for (int c = 0; c < 3; c++) begin
      #1;
      if (bus_req_valid) reqs++;
      chk(!req_ready, "R10 load waits on open request", int'(req_ready), 0);
      chk(bus_req_addr == 8'h30, "R11 address held", int'(bus_req_addr), 'h30);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h39;
    #1;
    chk(req_ready, "R10 prefetch while busy accepted", int'(req_ready), 1);
    @(negedge clk);
    req_kind = 2'd0; req_addr = 8'h30;
    bus_done = 1'b1; bus_shared = 1'b0;
    @(negedge clk);
    bus_done = 1'b0;
    #1;
    chk(req_ready && !bus_req_valid, "R10 merged load completes from fill", int'(req_ready), 1);
    chk(reqs == 3, "R10 single request while held", reqs, 3);
    @(negedge clk);
    req_valid = 1'b0;
    snoop(1'b1, 8'h39, sh, sw);
    chk(!sh, "R10 busy prefetch was dropped", int'(sh), 0);
    run_req(2'd0, 8'h39, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1, "R10 dropped line still misses", n, 1);
  endtask

  task automatic t_evict();
    int n; logic o, w; logic [1:0] h; logic [AW-1:0] ra;
    run_req(2'd1, 8'h42, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    run_req(2'd0, 8'h4A, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && w, "R12 Modified victim written back", int'(w), 1);
    run_req(2'd0, 8'h52, 2'd0, 1'b1, 1'b0, n, o, h, w, ra);
    chk(n == 1 && !w, "R12 clean victim not written back", int'(w), 0);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    t_reset();
    t_load_exclusive();
    t_load_shared();
    t_read_pf();
    t_write_pf();
    t_wp_off();
    t_bad_addr();
    t_merge();
    t_evict();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule